// File: doc/BRIEF.md
# Top-Level Page Table Entry Cache

This block keeps a small, fully associative store of decoded top-level (level-4) entries of a four-level page table, so that a page walker can skip the first memory read of a walk. A lookup presents a 48-bit linear address. One cycle later the block reports whether a stored entry covers the nine address bits 47:39. On a hit it also returns the physical address of the next-level table and the access and cache-control attributes.

The walker offers the raw 64-bit entry it has just fetched, along with the 9-bit index it used. The block screens the entry. Only an entry that is present, has already been marked accessed, and has no reserved bit set is installed. The block never checks what the next level holds. A stored entry is never refreshed from memory. It changes only when a new accepted fill carries the same index, or when the invalidate-all input wipes the store.

A controller classifies every cycle as one of five actions, chosen by priority: FLUSH (invalidate-all asserted), IDLE (no fill offered), DROP (fill refused by the screen), REFRESH (accepted fill whose index is already stored, rewritten in place), and ALLOC (accepted fill with a new index, written into the slot under a round-robin pointer, after which the pointer advances). The only state the controller keeps is that pointer.

Top module: `l4_entry_cache`

## Requirements
- R1: After reset every slot is empty and `rsp_valid` is low, so every lookup misses until a fill is accepted.
- R2: `rsp_valid` is high exactly one cycle after `lk_valid`. `rsp_hit` is high when a stored slot's index equals `lk_laddr[47:39]`. On a miss every returned field is zero.
- R3: A hit returns `rsp_table_pa` = entry bits PA_BITS-1:12 with bits 11:0 cleared, `rsp_rw` = bit 1, `rsp_us` = bit 2, `rsp_pwt` = bit 3, `rsp_pcd` = bit 4 and `rsp_xd` = bit 63 of the entry that was filled.
- R4: A fill whose present bit (bit 0) is 0 is refused and changes nothing.
- R5: A fill with bit 7 set, or with any bit from PA_BITS up to 51 set, is refused and changes nothing. Bit PA_BITS-1 is an address bit and does not cause a refusal.
- R6: A fill whose accessed bit (bit 5) is 0 is refused and changes nothing.
- R7: No other bit of the entry affects acceptance. Bits 6, 11:8 and 62:52 may hold any value.
- R8: An accepted fill whose index is already stored rewrites that slot in place, does not use another slot and does not move the replacement pointer. A refused fill leaves a stored slot exactly as it was.
- R9: An accepted fill with a new index goes into the slot under a round-robin pointer that starts at 0 and advances by one with wrap. With 8 slots, the ninth distinct index evicts the first one installed.
- R10: `inv_all` empties every slot in one cycle, resets the pointer to 0, and wins over a fill offered in the same cycle.
- R11: A lookup sees the contents as they were before any fill or flush in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_laddr | input | 48 | Linear address to look up |
| fill_valid | input | 1 | Fill offered |
| fill_index | input | 9 | Linear address bits 47:39 of the walk |
| fill_entry | input | 64 | Raw top-level entry from memory |
| inv_all | input | 1 | Invalidate every slot |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_table_pa | output | PA_BITS | Next-level table physical address |
| rsp_rw | output | 1 | Write-permitted attribute |
| rsp_us | output | 1 | User-access attribute |
| rsp_xd | output | 1 | Execute-disable attribute |
| rsp_pcd | output | 1 | Cache-disable attribute |
| rsp_pwt | output | 1 | Write-through attribute |

## Verification
A lookup result is due one clock edge after the request, and a fill or flush takes effect at the edge where it is offered. A lookup made in that same cycle therefore still sees the old contents, and a lookup one cycle later sees the new ones. The bench model captures its expected response at each rising edge from its state before that edge's update, and then applies the update. The bench drives and compares only on falling edges, so every compare reads the registered result of the previous rising edge.

// File: rtl/l4c_pkg.sv
package l4c_pkg;
    localparam int LA_W      = 48;
    localparam int TAG_W     = 9;
    localparam int TAG_LSB   = 39;
    localparam int PTE_W     = 64;
    localparam int PA_LIMIT  = 52;
    localparam int PAGE_BITS = 12;

    typedef struct packed {
        logic xd;
        logic pcd;
        logic pwt;
        logic us;
        logic rw;
    } l4c_attr_t;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_DROP,
        ACT_REFRESH,
        ACT_ALLOC,
        ACT_FLUSH
    } l4c_act_t;
endpackage

// File: rtl/l4c_fill_filter.sv
module l4c_fill_filter
    import l4c_pkg::*;
#(
    parameter int PA_BITS = 46,
    parameter int FRAME_W = PA_BITS - PAGE_BITS
) (
    input  logic [PTE_W-1:0]   pte,
    output logic               ok,
    output logic [FRAME_W-1:0] frame,
    output l4c_attr_t          attr
);
    function automatic logic [PTE_W-1:0] build_rsvd_mask();
        logic [PTE_W-1:0] m;
        m = '0;
        for (int b = PA_BITS; b < PA_LIMIT; b++) begin
            m[b] = 1'b1;
        end
        m[7] = 1'b1;
        return m;
    endfunction

    localparam logic [PTE_W-1:0] RSVD_MASK = build_rsvd_mask();

    logic present, accessed, rsvd_clear;

    always_comb begin
        present    = pte[0];
        accessed   = pte[5];
        rsvd_clear = ~|(pte & RSVD_MASK);
        ok         = present & accessed & rsvd_clear;
        frame      = pte[PA_BITS-1:PAGE_BITS];
        attr.rw    = pte[1];
        attr.us    = pte[2];
        attr.pwt   = pte[3];
        attr.pcd   = pte[4];
        attr.xd    = pte[63];
    end
endmodule

// File: rtl/l4c_entry_array.sv
module l4c_entry_array
    import l4c_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PA_BITS = 46,
    parameter int IDX_W   = $clog2(ENTRIES),
    parameter int FRAME_W = PA_BITS - PAGE_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_slot,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [FRAME_W-1:0] wr_frame,
    input  l4c_attr_t          wr_attr,
    input  logic [TAG_W-1:0]   lk_tag,
    output logic               lk_hit,
    output logic [FRAME_W-1:0] lk_frame,
    output l4c_attr_t          lk_attr,
    input  logic [TAG_W-1:0]   fl_tag,
    output logic               fl_hit,
    output logic [IDX_W-1:0]   fl_slot
);
    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q   [ENTRIES];
    logic [FRAME_W-1:0] frame_q [ENTRIES];
    l4c_attr_t          attr_q  [ENTRIES];

    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fl_match;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i]   <= '0;
                frame_q[i] <= '0;
                attr_q[i]  <= '0;
            end
        end else if (clear) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_slot] <= 1'b1;
            tag_q[wr_slot]   <= wr_tag;
            frame_q[wr_slot] <= wr_frame;
            attr_q[wr_slot]  <= wr_attr;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g] = valid_q[g] && (tag_q[g] == lk_tag);
        assign fl_match[g] = valid_q[g] && (tag_q[g] == fl_tag);
    end

    always_comb begin
        lk_frame = '0;
        lk_attr  = '0;
        fl_slot  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                lk_frame = lk_frame | frame_q[i];
                lk_attr  = lk_attr | attr_q[i];
            end
            if (fl_match[i]) begin
                fl_slot = fl_slot | IDX_W'(i);
            end
        end
        lk_hit = |lk_match;
        fl_hit = |fl_match;
    end

    p_unique_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (valid_q == '0));
    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear) |=> valid_q[$past(wr_slot)]);
endmodule

// File: rtl/l4c_ctrl.sv
module l4c_ctrl
    import l4c_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_all,
    input  logic             fill_valid,
    input  logic             fill_ok,
    input  logic             fill_hit,
    input  logic [IDX_W-1:0] fill_hit_slot,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_slot,
    output logic             clear
);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(ENTRIES - 1);

    l4c_act_t         act;
    logic [IDX_W-1:0] ptr_q, ptr_d;

    always_comb begin
        if (inv_all)          act = ACT_FLUSH;
        else if (!fill_valid) act = ACT_IDLE;
        else if (!fill_ok)    act = ACT_DROP;
        else if (fill_hit)    act = ACT_REFRESH;
        else                  act = ACT_ALLOC;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_comb begin
        wr_en   = 1'b0;
        wr_slot = ptr_q;
        clear   = 1'b0;
        ptr_d   = ptr_q;
        unique case (act)
            ACT_IDLE, ACT_DROP: begin
            end
            ACT_REFRESH: begin
                wr_en   = 1'b1;
                wr_slot = fill_hit_slot;
            end
            ACT_ALLOC: begin
                wr_en = 1'b1;
                ptr_d = (ptr_q == LAST_SLOT) ? '0 : ptr_q + 1'b1;
            end
            ACT_FLUSH: begin
                clear = 1'b1;
                ptr_d = '0;
            end
            default: begin
            end
        endcase
    end

    p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_REFRESH || act == ACT_DROP || act == ACT_IDLE) |=> $stable(ptr_q));
    p_ptr_home_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (ptr_q == '0));
endmodule

// File: rtl/l4_entry_cache.sv
module l4_entry_cache
    import l4c_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PA_BITS = 46
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [LA_W-1:0]    lk_laddr,
    input  logic               fill_valid,
    input  logic [TAG_W-1:0]   fill_index,
    input  logic [PTE_W-1:0]   fill_entry,
    input  logic               inv_all,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [PA_BITS-1:0] rsp_table_pa,
    output logic               rsp_rw,
    output logic               rsp_us,
    output logic               rsp_xd,
    output logic               rsp_pcd,
    output logic               rsp_pwt
);
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int FRAME_W = PA_BITS - PAGE_BITS;

    logic               f_ok;
    logic [FRAME_W-1:0] f_frame;
    l4c_attr_t          f_attr;
    logic               a_hit, a_fl_hit;
    logic [FRAME_W-1:0] a_frame;
    l4c_attr_t          a_attr;
    logic [IDX_W-1:0]   a_fl_slot;
    logic               wr_en, clear;
    logic [IDX_W-1:0]   wr_slot;
    logic [TAG_W-1:0]   lk_tag;
    logic               unused_low;

    assign lk_tag     = lk_laddr[LA_W-1:TAG_LSB];
    assign unused_low = ^lk_laddr[TAG_LSB-1:0];

    l4c_fill_filter #(.PA_BITS(PA_BITS)) u_filter (
        .pte(fill_entry), .ok(f_ok), .frame(f_frame), .attr(f_attr)
    );

    l4c_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all), .fill_valid(fill_valid),
        .fill_ok(f_ok), .fill_hit(a_fl_hit), .fill_hit_slot(a_fl_slot),
        .wr_en(wr_en), .wr_slot(wr_slot), .clear(clear)
    );

    l4c_entry_array #(.ENTRIES(ENTRIES), .PA_BITS(PA_BITS)) u_array (
        .clk(clk), .rst_n(rst_n), .clear(clear), .wr_en(wr_en), .wr_slot(wr_slot),
        .wr_tag(fill_index), .wr_frame(f_frame), .wr_attr(f_attr),
        .lk_tag(lk_tag), .lk_hit(a_hit), .lk_frame(a_frame), .lk_attr(a_attr),
        .fl_tag(fill_index), .fl_hit(a_fl_hit), .fl_slot(a_fl_slot)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_table_pa <= '0;
            {rsp_xd, rsp_pcd, rsp_pwt, rsp_us, rsp_rw} <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && a_hit;
            if (lk_valid && a_hit) begin
                rsp_table_pa <= {a_frame, {PAGE_BITS{1'b0}}};
                {rsp_xd, rsp_pcd, rsp_pwt, rsp_us, rsp_rw} <= a_attr;
            end else begin
                rsp_table_pa <= '0;
                {rsp_xd, rsp_pcd, rsp_pwt, rsp_us, rsp_rw} <= '0;
            end
        end
    end

    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    p_rsp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_table_pa == '0));
    p_needs_present_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> fill_entry[0]);
    p_rsvd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !fill_entry[7]);
    p_needs_accessed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> fill_entry[5]);
    p_flush_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |-> !wr_en);
endmodule

// File: tb/l4_entry_cache_test.sv
module l4_entry_cache_test;
    localparam int N  = 8;
    localparam int PA = 46;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [47:0]   lk_laddr = '0;
    logic          fill_valid = 1'b0;
    logic [8:0]    fill_index = '0;
    logic [63:0]   fill_entry = '0;
    logic          inv_all = 1'b0;
    logic          rsp_valid, rsp_hit, rsp_rw, rsp_us, rsp_xd, rsp_pcd, rsp_pwt;
    logic [PA-1:0] rsp_table_pa;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    l4_entry_cache #(.ENTRIES(N), .PA_BITS(PA)) uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_laddr(lk_laddr),
        .fill_valid(fill_valid), .fill_index(fill_index), .fill_entry(fill_entry),
        .inv_all(inv_all), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_table_pa(rsp_table_pa), .rsp_rw(rsp_rw), .rsp_us(rsp_us),
        .rsp_xd(rsp_xd), .rsp_pcd(rsp_pcd), .rsp_pwt(rsp_pwt)
    );

    // behavioural reference model
    bit          m_valid [N];
    logic [8:0]  m_tag   [N];
    logic [63:0] m_pte   [N];
    int          m_ptr;
    bit          e_valid, e_hit;
    logic [63:0] e_pte;
    string       e_req;

    function automatic bit accept(logic [63:0] p);
        if (!p[0] || !p[5] || p[7]) return 0;
        for (int b = PA; b < 52; b++) if (p[b]) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_valid[i] = 0;
            m_ptr = 0; e_valid = 0; e_hit = 0; e_pte = '0; e_req = "R1";
        end else begin
            e_valid = lk_valid; e_hit = 0; e_pte = '0; e_req = cur_req;
            if (lk_valid)
                for (int i = 0; i < N; i++)
                    if (m_valid[i] && m_tag[i] == lk_laddr[47:39]) begin
                        e_hit = 1; e_pte = m_pte[i];
                    end
            if (inv_all) begin
                for (int i = 0; i < N; i++) m_valid[i] = 0;
                m_ptr = 0;
            end else if (fill_valid && accept(fill_entry)) begin
                int slot;
                slot = -1;
                for (int i = 0; i < N; i++)
                    if (m_valid[i] && m_tag[i] == fill_index) slot = i;
                if (slot < 0) begin
                    slot = m_ptr;
                    m_ptr = (m_ptr + 1) % N;
                end
                m_valid[slot] = 1; m_tag[slot] = fill_index; m_pte[slot] = fill_entry;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            checks++;
            if (rsp_valid !== 1'b0) begin
                fails++;
                $display("FAIL R1 rsp_valid in reset act=%b exp=0", rsp_valid);
            end
        end else begin
            logic [PA-1:0] epa;
            logic [4:0]    eat;
            epa = e_hit ? {e_pte[PA-1:12], 12'h000} : '0;
            eat = e_hit ? {e_pte[63], e_pte[4], e_pte[3], e_pte[2], e_pte[1]} : 5'b0;
            checks++;
            if (rsp_valid !== e_valid) begin
                fails++;
                $display("FAIL R2 rsp_valid act=%b exp=%b", rsp_valid, e_valid);
            end
            if (e_valid) begin
                checks++;
                if (rsp_hit !== e_hit || rsp_table_pa !== epa ||
                    {rsp_xd, rsp_pcd, rsp_pwt, rsp_us, rsp_rw} !== eat) begin
                    fails++;
                    $display("FAIL %s hit/pa/attr act=%b/%h/%b exp=%b/%h/%b", e_req,
                             rsp_hit, rsp_table_pa, {rsp_xd, rsp_pcd, rsp_pwt, rsp_us, rsp_rw},
                             e_hit, epa, eat);
                end
            end
        end
    end

    function automatic logic [63:0] good(logic [PA-1:0] pa, logic [4:0] at);
        logic [63:0] p;
        p = '0;
        p[PA-1:12] = pa[PA-1:12];
        p[0] = 1'b1; p[5] = 1'b1;
        p[1] = at[0]; p[2] = at[1]; p[3] = at[2]; p[4] = at[3]; p[63] = at[4];
        return p;
    endfunction

    task automatic cyc(bit lv, logic [8:0] lt, bit fv, logic [8:0] ft, logic [63:0] fp, bit inv);
        @(negedge clk);
        lk_valid = lv; lk_laddr = {lt, 39'h12_3456_789A};
        fill_valid = fv; fill_index = ft; fill_entry = fp; inv_all = inv;
    endtask
    task automatic look(logic [8:0] t); cyc(1, t, 0, 0, '0, 0); endtask
    task automatic fill(logic [8:0] t, logic [63:0] p); cyc(0, 0, 1, t, p, 0); endtask
    task automatic flush(); cyc(0, 0, 0, 0, '0, 1); endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] p;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1"; look(9'd0); look(9'd511); look(9'd5);
        cur_req = "R2"; cyc(0, 0, 0, 0, '0, 0); look(9'd5);
        cur_req = "R3";
        fill(9'd5, good(46'h2A_BCDE_F000, 5'b10101)); look(9'd5); look(9'd4);
        fill(9'd0, good(46'h3FFF_FFFF_F000, 5'b01010)); look(9'd0);
        fill(9'd511, good(46'h1000, 5'b11111)); look(9'd511);
        cur_req = "R4";
        p = good(46'h7000, 5'b0); p[0] = 0; fill(9'd6, p); look(9'd6);
        cur_req = "R5";
        p = good(46'h8000, 5'b0); p[7] = 1; fill(9'd7, p); look(9'd7);
        p = good(46'h8000, 5'b0); p[51] = 1; fill(9'd8, p); look(9'd8);
        p = good(46'h8000, 5'b0); p[PA] = 1; fill(9'd9, p); look(9'd9);
        p = good(46'h2000_0000_8000, 5'b0); fill(9'd10, p); look(9'd10);
        cur_req = "R6";
        p = good(46'h9000, 5'b1); p[5] = 0; fill(9'd11, p); look(9'd11);
        cur_req = "R7";
        p = good(46'hA000, 5'b00110); p[6] = 1; p[11:8] = 4'hF; p[62:52] = 11'h7FF;
        fill(9'd12, p); look(9'd12);
        cur_req = "R8";
        fill(9'd5, good(46'hB000, 5'b00001)); look(9'd5);
        p = good(46'hC000, 5'b0); p[5] = 0; fill(9'd5, p); look(9'd5);
        look(9'd0); look(9'd511); look(9'd10); look(9'd12);
        cur_req = "R9";
        flush();
        for (int k = 0; k < 9; k++) fill(9'(100 + k), good(46'(64'h1000 * (k + 1)), 5'(k)));
        for (int k = 0; k < 9; k++) look(9'(100 + k));
        fill(9'd120, good(46'hF000, 5'b0)); look(9'd101); look(9'd120);
        cur_req = "R10";
        cyc(0, 0, 1, 9'd130, good(46'hD000, 5'b0), 1); look(9'd130); look(9'd102);
        fill(9'd140, good(46'hE000, 5'b0)); look(9'd140);
        cur_req = "R11";
        cyc(1, 9'd150, 1, 9'd150, good(46'h5000, 5'b1), 0); look(9'd150);
        cyc(1, 9'd150, 0, 0, '0, 1); look(9'd150);
        cyc(0, 0, 0, 0, '0, 0); cyc(0, 0, 0, 0, '0, 0);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule